// File: doc/BRIEF.md
# Flash Operation Status Tracker

This block holds the status word of a flash program/erase sequencer. The operation engine, which owns the pulse timing and the array, sends single-cycle event strobes: start and completion of a program or an erase, suspend, resume, and five kinds of failure. The host sends two clear commands. The block turns these strobes into a read-only status word with a busy bit, one active bit per operation, one sticky suspend flag per operation and a set of sticky error flags.

The active bits follow suspend and resume. A suspend clears the active bit and sets the matching suspend flag. A resume sets the active bit again and clears that flag. Any failure during an operation stops it in the same cycle. The command-status flag then stays set until a clear-status command, which is the only command that clears it. Every result appears in the status word one clock edge after the strobe that causes it.

Top module: `fop_status_track`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, the status word reads all zeros.
- R2: A program start seen while the block is idle sets program-active (bit 6) and busy (bit 8) after the next edge. Idle means no operation is active and no suspend flag is set. A program completion clears both bits. A start that arrives while an operation is active or suspended is ignored. If both starts arrive together while idle, the program start wins.
- R3: An erase start seen while idle sets erase-active (bit 7) and busy. An erase completion clears both. A completion strobe for the operation that is not running is ignored.
- R4: A suspend while an operation is active clears its active bit and sets its suspend flag (bit 1 for program, bit 2 for erase). Busy stays high for exactly the cycle in which the suspend is processed, then falls. A suspend with no active operation is ignored.
- R5: A resume while a suspend flag is set clears that flag and sets the matching active bit and busy again. A resume with no suspend pending is ignored.
- R6: Clear-more clears both suspend flags, which abandons a suspended operation. It also clears program-verify, erase-verify, invalid-data and voltage, but it leaves command-status unchanged.
- R7: During an active operation, program-verify failure sets bit 12, erase-verify failure sets bit 10, invalid-data sets bit 5 and voltage dip sets bit 3. Each of these, and a generic command failure, also sets command-status (bit 4).
- R8: A failure clears the active bits and busy in the same edge that sets command-status. It wins over a completion or suspend strobe that arrives in the same cycle.
- R9: A failure strobe that arrives while no operation is active changes nothing.
- R10: Clear-status clears all five error flags. An error that is set in the same cycle as a clear wins over the clear.
- R11: Bits 0, 9, 11 and bits 13 and above of the status word always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pgm_start_i | input | 1 | Program operation begins |
| pgm_done_i | input | 1 | Program operation completed |
| ers_start_i | input | 1 | Erase operation begins |
| ers_done_i | input | 1 | Erase operation completed |
| susp_i | input | 1 | Suspend the running operation |
| resume_i | input | 1 | Resume the suspended operation |
| pv_fail_i | input | 1 | Program verify failed after the pulse limit |
| ev_fail_i | input | 1 | Erase verify failed after the pulse limit |
| invd_i | input | 1 | Attempt to program a 1 over a 0 |
| vdip_i | input | 1 | Core supply fell below its limit |
| cmd_fail_i | input | 1 | Generic command failure |
| clr_stat_i | input | 1 | Host clear-status command |
| clr_more_i | input | 1 | Host clear-more command |
| status_o | output | STAT_W | Status word |

## Verification
Every flag is a single register stage away from its inputs. A strobe driven before a rising edge is therefore visible in the status word after that same edge. Busy takes a one-cycle detour during suspend, which the model expects in the cycle right after the suspend strobe. The bench drives strobes on the falling edge and steps its own mode-based model once per rising edge. It then compares the whole status word on the following falling edge, so every check lands exactly one edge after its stimulus.

// File: rtl/fst_pkg.sv
package fst_pkg;
   localparam int unsigned MIN_STAT_W = 13;
   localparam int unsigned NUM_ERR    = 5;
   localparam int unsigned NUM_FIELD  = 10;

   // error flag slots inside the error bank
   localparam int unsigned E_PVF   = 0;
   localparam int unsigned E_EVF   = 1;
   localparam int unsigned E_INVD  = 2;
   localparam int unsigned E_VOLT  = 3;
   localparam int unsigned E_CSTAT = 4;

   // status word bit positions (read by software)
   localparam int unsigned B_PSUSP = 1;
   localparam int unsigned B_ESUSP = 2;
   localparam int unsigned B_VOLT  = 3;
   localparam int unsigned B_CSTAT = 4;
   localparam int unsigned B_INVD  = 5;
   localparam int unsigned B_PACT  = 6;
   localparam int unsigned B_EACT  = 7;
   localparam int unsigned B_BUSY  = 8;
   localparam int unsigned B_EVF   = 10;
   localparam int unsigned B_PVF   = 12;

   typedef struct packed {
      logic busy;
      logic eact;
      logic pact;
      logic esusp;
      logic psusp;
   } act_s;
endpackage

// File: rtl/fst_op_track.sv
module fst_op_track (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         pgm_start_i,
   input  logic         pgm_done_i,
   input  logic         ers_start_i,
   input  logic         ers_done_i,
   input  logic         susp_i,
   input  logic         resume_i,
   input  logic         clr_more_i,
   input  logic         fail_i,
   output logic         live_o,
   output fst_pkg::act_s act_o
);
   logic pact_q, eact_q, psusp_q, esusp_q, busy_q;
   logic pact_n, eact_n, psusp_n, esusp_n, busy_n;
   logic live, idle, fin, susp_ok;

   assign live    = pact_q | eact_q;
   assign idle    = !live && !psusp_q && !esusp_q;
   assign fin     = (pact_q & pgm_done_i) | (eact_q & ers_done_i);
   assign susp_ok = live & susp_i & !fail_i & !fin;

   always_comb begin
      pact_n  = pact_q;
      eact_n  = eact_q;
      psusp_n = psusp_q;
      esusp_n = esusp_q;
      if (fail_i || fin) begin
         pact_n = 1'b0;
         eact_n = 1'b0;
      end else if (susp_ok) begin
         psusp_n = pact_q;
         esusp_n = eact_q;
         pact_n  = 1'b0;
         eact_n  = 1'b0;
      end else if (resume_i && psusp_q) begin
         psusp_n = 1'b0;
         pact_n  = 1'b1;
      end else if (resume_i && esusp_q) begin
         esusp_n = 1'b0;
         eact_n  = 1'b1;
      end else if (clr_more_i && (psusp_q || esusp_q)) begin
         psusp_n = 1'b0;
         esusp_n = 1'b0;
      end else if (idle && pgm_start_i) begin
         pact_n = 1'b1;
      end else if (idle && ers_start_i) begin
         eact_n = 1'b1;
      end
      busy_n = pact_n | eact_n | susp_ok;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pact_q  <= 1'b0;
         eact_q  <= 1'b0;
         psusp_q <= 1'b0;
         esusp_q <= 1'b0;
         busy_q  <= 1'b0;
      end else begin
         pact_q  <= pact_n;
         eact_q  <= eact_n;
         psusp_q <= psusp_n;
         esusp_q <= esusp_n;
         busy_q  <= busy_n;
      end
   end

   assign live_o      = live;
   assign act_o.busy  = busy_q;
   assign act_o.eact  = eact_q;
   assign act_o.pact  = pact_q;
   assign act_o.esusp = esusp_q;
   assign act_o.psusp = psusp_q;

   AST_ACT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(pact_q && eact_q)); // R2
   AST_BUSY_COVER: assert property (@(posedge clk) disable iff (!rst_n)
      (pact_q || eact_q) |-> busy_q); // R2
   AST_SUSP_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
      (psusp_q || esusp_q) |-> !(pact_q || eact_q)); // R4
   AST_LONE_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
      (resume_i && !psusp_q && !esusp_q && !live && !pgm_start_i && !ers_start_i)
      |=> (!pact_q && !eact_q)); // R5
   AST_FAIL_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      fail_i |=> (!pact_q && !eact_q && !busy_q)); // R8
endmodule

// File: rtl/fst_err_bank.sv
module fst_err_bank #(
   parameter int unsigned  N         = 5,
   parameter logic [N-1:0] MORE_MASK = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic         clr_all_i,
   input  logic         clr_more_i,
   output logic [N-1:0] flags_o
);
   if (N < 1) begin : g_bad_n
      $error("fst_err_bank: N must be at least 1");
   end

   for (genvar g = 0; g < N; g++) begin : g_flag
      logic clr;
      assign clr = clr_all_i | (MORE_MASK[g] & clr_more_i);

      always_ff @(posedge clk) begin
         if (!rst_n)        flags_o[g] <= 1'b0;
         else if (set_i[g]) flags_o[g] <= 1'b1;
         else if (clr)      flags_o[g] <= 1'b0;
      end

      AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
         set_i[g] |=> flags_o[g]); // R10
      if (!MORE_MASK[g]) begin : g_sticky
         AST_ONLY_CLR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
            (flags_o[g] && !clr_all_i) |=> flags_o[g]); // R6
      end
   end
endmodule

// File: rtl/fst_stat_pack.sv
module fst_stat_pack #(
   parameter int unsigned STAT_W = 32
) (
   input  fst_pkg::act_s                 act_i,
   input  logic [fst_pkg::NUM_ERR-1:0]   err_i,
   output logic [STAT_W-1:0]             word_o
);
   import fst_pkg::*;

   if (STAT_W < MIN_STAT_W) begin : g_bad_w
      $error("fst_stat_pack: STAT_W too narrow for the field map");
   end

   localparam int unsigned POS [NUM_FIELD] = '{
      B_PSUSP, B_ESUSP, B_VOLT, B_CSTAT, B_INVD,
      B_PACT, B_EACT, B_BUSY, B_EVF, B_PVF};

   logic [NUM_FIELD-1:0] fld;
   assign fld = {err_i[E_PVF], err_i[E_EVF], act_i.busy, act_i.eact, act_i.pact,
                 err_i[E_INVD], err_i[E_CSTAT], err_i[E_VOLT], act_i.esusp, act_i.psusp};

   always_comb begin
      word_o = '0;
      for (int i = 0; i < NUM_FIELD; i++) word_o[POS[i]] = fld[i];
   end
endmodule

// File: rtl/fop_status_track.sv
module fop_status_track #(
   parameter int unsigned STAT_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pgm_start_i,
   input  logic              pgm_done_i,
   input  logic              ers_start_i,
   input  logic              ers_done_i,
   input  logic              susp_i,
   input  logic              resume_i,
   input  logic              pv_fail_i,
   input  logic              ev_fail_i,
   input  logic              invd_i,
   input  logic              vdip_i,
   input  logic              cmd_fail_i,
   input  logic              clr_stat_i,
   input  logic              clr_more_i,
   output logic [STAT_W-1:0] status_o
);
   import fst_pkg::*;

   localparam logic [NUM_ERR-1:0] MORE_MASK = ~(NUM_ERR'(1) << E_CSTAT);

   logic               live, fail;
   logic [NUM_ERR-1:0] err_raw, err_set, err_q;
   act_s               act;

   always_comb begin
      err_raw          = '0;
      err_raw[E_PVF]   = pv_fail_i;
      err_raw[E_EVF]   = ev_fail_i;
      err_raw[E_INVD]  = invd_i;
      err_raw[E_VOLT]  = vdip_i;
      err_raw[E_CSTAT] = cmd_fail_i;
   end

   assign fail = live & (|err_raw);

   always_comb begin
      err_set          = err_raw & {NUM_ERR{live}};
      err_set[E_CSTAT] = fail;
   end

   fst_op_track u_op (
      .clk         (clk),
      .rst_n       (rst_n),
      .pgm_start_i (pgm_start_i),
      .pgm_done_i  (pgm_done_i),
      .ers_start_i (ers_start_i),
      .ers_done_i  (ers_done_i),
      .susp_i      (susp_i),
      .resume_i    (resume_i),
      .clr_more_i  (clr_more_i),
      .fail_i      (fail),
      .live_o      (live),
      .act_o       (act)
   );

   fst_err_bank #(.N(NUM_ERR), .MORE_MASK(MORE_MASK)) u_err (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_i      (err_set),
      .clr_all_i  (clr_stat_i),
      .clr_more_i (clr_more_i),
      .flags_o    (err_q)
   );

   fst_stat_pack #(.STAT_W(STAT_W)) u_pack (
      .act_i  (act),
      .err_i  (err_q),
      .word_o (status_o)
   );

   AST_IDLE_FAIL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (!live && !clr_stat_i && !clr_more_i) |=> $stable(err_q)); // R9
   AST_FAIL_SETS_CSTAT: assert property (@(posedge clk) disable iff (!rst_n)
      fail |=> status_o[B_CSTAT]); // R7
endmodule

// File: tb/tb_fop_status_track.sv
module tb_fop_status_track;
   localparam int W = 32;
   localparam int S_PST = 0, S_PDN = 1, S_EST = 2, S_EDN = 3, S_SUS = 4, S_RES = 5,
                  S_PVF = 6, S_EVF = 7, S_INV = 8, S_VDP = 9, S_CFL = 10,
                  S_CST = 11, S_CMR = 12;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [12:0] s = '0;
   logic [W-1:0] status;
   int nvec = 0, nbad = 0;
   bit done_flag = 0;

   always #2 clk = ~clk;

   fop_status_track #(.STAT_W(W)) dut (
      .clk(clk), .rst_n(rst_n),
      .pgm_start_i(s[S_PST]), .pgm_done_i(s[S_PDN]),
      .ers_start_i(s[S_EST]), .ers_done_i(s[S_EDN]),
      .susp_i(s[S_SUS]), .resume_i(s[S_RES]),
      .pv_fail_i(s[S_PVF]), .ev_fail_i(s[S_EVF]), .invd_i(s[S_INV]),
      .vdip_i(s[S_VDP]), .cmd_fail_i(s[S_CFL]),
      .clr_stat_i(s[S_CST]), .clr_more_i(s[S_CMR]),
      .status_o(status));

   // reference model: mode 0 idle, 1 program, 2 erase, 3 program held, 4 erase held
   int mode = 0;
   bit spulse = 0, m_pv = 0, m_ev = 0, m_inv = 0, m_vs = 0, m_cs = 0;

   function automatic logic [W-1:0] expected();
      logic [W-1:0] w = '0;
      w[12] = m_pv;  w[10] = m_ev;  w[8] = (mode == 1 || mode == 2 || spulse);
      w[7] = (mode == 2); w[6] = (mode == 1); w[5] = m_inv; w[4] = m_cs;
      w[3] = m_vs; w[2] = (mode == 4); w[1] = (mode == 3);
      return w;
   endfunction

   task automatic model_step(input logic [12:0] v);
      bit running = (mode == 1 || mode == 2);
      bit f = running && (v[S_PVF] || v[S_EVF] || v[S_INV] || v[S_VDP] || v[S_CFL]);
      if (v[S_CST]) begin m_pv = 0; m_ev = 0; m_inv = 0; m_vs = 0; m_cs = 0; end
      if (v[S_CMR]) begin m_pv = 0; m_ev = 0; m_inv = 0; m_vs = 0; end
      if (f) begin
         if (v[S_PVF]) m_pv = 1;
         if (v[S_EVF]) m_ev = 1;
         if (v[S_INV]) m_inv = 1;
         if (v[S_VDP]) m_vs = 1;
         m_cs = 1;
      end
      spulse = 0;
      if (f) mode = 0;
      else if ((mode == 1 && v[S_PDN]) || (mode == 2 && v[S_EDN])) mode = 0;
      else if (running && v[S_SUS]) begin mode = mode + 2; spulse = 1; end
      else if ((mode == 3 || mode == 4) && v[S_RES]) mode = mode - 2;
      else if ((mode == 3 || mode == 4) && v[S_CMR]) mode = 0;
      else if (mode == 0 && v[S_PST]) mode = 1;
      else if (mode == 0 && v[S_EST]) mode = 2;
   endtask

   task automatic check(input string tag);
      logic [W-1:0] e = expected();
      nvec++;
      if (status !== e) begin
         nbad++;
         $display("FAIL %s: status got %h expected %h", tag, status, e);
      end
   endtask

   // drive at negedge, model after posedge, compare at next negedge
   task automatic cyc(input logic [12:0] v, input string tag);
      s = v;
      @(posedge clk);
      model_step(v);
      @(negedge clk);
      s = '0;
      check(tag);
   endtask

   function automatic logic [12:0] b(input int i);
      return 13'(1) << i;
   endfunction

   initial begin
      #400000;
      if (!done_flag) begin
         nbad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
         $finish;
      end
   end

   initial begin
      @(negedge clk); @(negedge clk);
      check("R1");                               // R1 zero during reset
      s = b(S_PST) | b(S_PVF);                   // strobes under reset ignored
      @(negedge clk); s = '0; check("R1");
      rst_n = 1'b1;
      @(posedge clk); @(negedge clk); check("R1");
      check("R11");
      // program run, start ignored while busy
      cyc(b(S_PST), "R2");
      cyc(b(S_EST), "R2");
      cyc(b(S_PST), "R2");
      cyc(b(S_EDN), "R3");
      cyc(b(S_PDN), "R2");
      cyc('0, "R2");
      // erase with suspend/resume
      cyc(b(S_EST), "R3");
      cyc(b(S_SUS), "R4");
      cyc('0, "R4");
      cyc(b(S_PST), "R2");
      cyc(b(S_SUS), "R4");
      cyc(b(S_RES), "R5");
      cyc(b(S_EDN), "R3");
      // stray strobes while idle
      cyc(b(S_RES), "R5");
      cyc(b(S_SUS), "R4");
      cyc(b(S_PDN) | b(S_EDN), "R3");
      // both starts: program wins
      cyc(b(S_PST) | b(S_EST), "R2");
      cyc(b(S_SUS), "R4");
      cyc(b(S_CMR), "R6");
      cyc(b(S_RES), "R5");
      // error flags
      cyc(b(S_PST), "R7");
      cyc(b(S_PVF) | b(S_PDN), "R8");
      cyc(b(S_EST), "R7");
      cyc(b(S_EVF) | b(S_SUS), "R8");
      cyc(b(S_PST), "R7");
      cyc(b(S_INV), "R7");
      cyc(b(S_EST), "R7");
      cyc(b(S_VDP), "R7");
      cyc(b(S_CMR), "R6");
      cyc(b(S_CST), "R10");
      cyc(b(S_PST), "R7");
      cyc(b(S_CFL), "R7");
      cyc(b(S_CMR), "R6");
      // failures while idle ignored
      cyc(b(S_PVF) | b(S_EVF) | b(S_INV) | b(S_VDP) | b(S_CFL), "R9");
      cyc(b(S_CST), "R10");
      // set beats clear
      cyc(b(S_EST), "R10");
      cyc(b(S_EVF) | b(S_CST) | b(S_CMR), "R10");
      cyc(b(S_CST), "R10");
      // suspended op cannot fail
      cyc(b(S_PST), "R9");
      cyc(b(S_SUS), "R4");
      cyc(b(S_CFL), "R9");
      cyc(b(S_RES) | b(S_CMR), "R5");
      cyc(b(S_PDN), "R2");
      // sparse random strobes
      void'($urandom(32'd91));
      for (int k = 0; k < 2000; k++) begin
         logic [12:0] v = '0;
         for (int i = 0; i < 13; i++) v[i] = ($urandom_range(9) == 0);
         cyc(v, "R11");
      end
      done_flag = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end
endmodule